// File: doc/BRIEF.md
# Power-of-Two Decimating Sample Latch

This block thins a full-rate 8-bit sample stream by a ratio of 1/2^k and holds each retained sample steady for a slower consumer, such as a reconstruction DAC or a capture cable. A 3-bit select code picks k from 0 to 7, which gives ratios from 1/1 to 1/128. A free-running 7-bit phase counter marks which samples are kept. A retained sample is the one that arrives on an edge where the low k counter bits are all zero.

Each kept sample is registered once. It appears on the data output one clock after its capture edge. A strobe pulses for that same single cycle, so the strobe rate equals the input rate times the ratio. A second data output carries a copy for the DAC. That copy is bitwise inverted by default, and a polarity input can pass it straight through so that the reconstructed waveform flips.

A new select code is adopted only on the edge where the phase counter wraps from 127 to 0. This means an output period is never cut short. A synchronous reset clears the counter and the output register, and it loads the select code at once.

Top module: `dec_latch_top`

## Requirements
- R1: Select code k (000 to 111) keeps exactly 128 >> k samples in every 128-cycle counter frame, which is one sample per 2^k input cycles.
- R2: A sample is kept on an edge where the low k bits of the phase counter are zero. Its value appears on `dec_o` one clock after that edge.
- R3: Between kept samples, `dec_o` holds its last value, so each value lasts 2^k input cycles.
- R4: `dec_stb_o` is high for exactly one cycle, the cycle that follows each kept-sample edge, and it is low at all other times.
- R5: With `flip_i` = 0, `dac_o` is the bitwise inverse of `dec_o`.
- R6: With `flip_i` = 1, `dac_o` equals `dec_o`.
- R7: A change on `ratio_sel_i` is adopted only on the edge where the counter goes from 127 to 0. That edge uses the select value present on it. The frame that is in progress finishes at the old ratio.
- R8: A synchronous reset (`rst_i` = 1 at an edge) clears the counter, `dec_o` and `dec_stb_o`, and loads `ratio_sel_i`. The first edge after release keeps a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Full-rate sample clock |
| rst_i | input | 1 | Synchronous reset, active high |
| smp_i | input | 8 | Converter sample |
| ratio_sel_i | input | 3 | Decimation code k, ratio 1/2^k |
| flip_i | input | 1 | 1 passes the DAC copy uninverted |
| dec_o | output | 8 | Held decimated sample |
| dec_stb_o | output | 1 | One-cycle pulse per new held sample |
| dac_o | output | 8 | DAC copy of `dec_o`, inverted unless `flip_i` = 1 |

## Verification
The hardest case to reach from the ports is a select change that lands inside a frame. It must leave the rest of that frame at the old ratio, and it must take effect exactly at the wrap. The stimulus changes the code mid-frame, and again on the very last cycle of a frame. It then counts strobes frame by frame against an arithmetic model that adopts the code only at index 127. Every code is also swept for a full frame right after reset, with flip alternating.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = (1 << CODE_W) - 1;
  localparam int CNT_W1 = CNT_W + 1;

  // mask of counter bits that must be zero for a kept sample
  function automatic logic [CNT_W-1:0] low_mask(input logic [CODE_W-1:0] code);
    logic [CNT_W1-1:0] one_hot;
    one_hot = CNT_W1'(1) << code;
    return CNT_W'(one_hot - CNT_W1'(1));
  endfunction

  // number of kept samples in one full counter frame
  function automatic logic [CNT_W1-1:0] frame_keeps(input logic [CODE_W-1:0] code);
    return CNT_W1'(1) << (CNT_W - int'(code));
  endfunction
endpackage

// File: rtl/dec_divider.sv
module dec_divider
  import dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sel,
  output logic              keep_o,
  output logic              wrap_o,
  output logic [CODE_W-1:0] code_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;

  assign wrap_o = &cnt_q;
  assign keep_o = (cnt_q & low_mask(code_q)) == '0;
  assign code_o = code_q;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= sel;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (wrap_o) code_q <= sel;
    end
  end
endmodule

// File: rtl/dec_capture.sv
module dec_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          keep,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      stb  <= 1'b0;
    end else begin
      stb <= keep;
      if (keep) dout <= din;
    end
  end
endmodule

// File: rtl/dec_dac_encode.sv
module dec_dac_encode #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] din,
  input  logic          flip,
  output logic [DW-1:0] dout
);
  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign dout[b] = flip ? din[b] : ~din[b];
  end
endmodule

// File: rtl/dec_latch_top.sv
module dec_latch_top
  import dec_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DW-1:0]     smp_i,
  input  logic [CODE_W-1:0] ratio_sel_i,
  input  logic              flip_i,
  output logic [DW-1:0]     dec_o,
  output logic              dec_stb_o,
  output logic [DW-1:0]     dac_o
);
  // named internal events for the checker
  logic              keep_w;
  logic              wrap_w;
  logic [CODE_W-1:0] code_w;
  logic [CNT_W-1:0]  cnt_w;

  dec_divider u_div (
    .clk    (clk_i),
    .rst    (rst_i),
    .sel    (ratio_sel_i),
    .keep_o (keep_w),
    .wrap_o (wrap_w),
    .code_o (code_w),
    .cnt_o  (cnt_w)
  );

  dec_capture #(.DW(DW)) u_cap (
    .clk  (clk_i),
    .rst  (rst_i),
    .keep (keep_w),
    .din  (smp_i),
    .dout (dec_o),
    .stb  (dec_stb_o)
  );

  dec_dac_encode #(.DW(DW)) u_enc (
    .din  (dec_o),
    .flip (flip_i),
    .dout (dac_o)
  );
endmodule

// File: rtl/dec_latch_chk.sv
module dec_latch_chk
  import dec_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              keep,
  input logic              wrap,
  input logic [CODE_W-1:0] code,
  input logic [CNT_W-1:0]  cnt,
  input logic [DW-1:0]     smp,
  input logic [DW-1:0]     dec,
  input logic              stb,
  input logic [DW-1:0]     dac,
  input logic              flip
);
  logic [CNT_W1-1:0] keeps_seen;

  always_ff @(posedge clk) begin
    if (rst || wrap) keeps_seen <= '0;
    else             keeps_seen <= keeps_seen + CNT_W1'(keep);
  end

  p_frame_count_r1: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (keeps_seen + CNT_W1'(keep)) == frame_keeps(code));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    keep |=> dec == $past(smp));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !keep |=> $stable(dec));

  p_strobe_on_r4: assert property (@(posedge clk) disable iff (rst)
    keep |=> stb);

  p_strobe_off_r4: assert property (@(posedge clk) disable iff (rst)
    !keep |=> !stb);

  p_dac_inverted_r5: assert property (@(posedge clk) disable iff (rst)
    !flip |-> (dac ^ dec) == {DW{1'b1}});

  p_dac_direct_r6: assert property (@(posedge clk) disable iff (rst)
    flip |-> dac == dec);

  p_code_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(code));

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cnt == '0) && (dec == '0) && !stb);
endmodule

bind dec_latch_top dec_latch_chk #(.DW(DW)) u_chk (
  .clk  (clk_i),
  .rst  (rst_i),
  .keep (keep_w),
  .wrap (wrap_w),
  .code (code_w),
  .cnt  (cnt_w),
  .smp  (smp_i),
  .dec  (dec_o),
  .stb  (dec_stb_o),
  .dac  (dac_o),
  .flip (flip_i)
);

// File: tb/tb_dec_latch_top.sv
module tb_dec_latch_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] smp = '0;
  logic [2:0] sel = '0;
  logic       flip = 1'b0;
  logic [7:0] dec_o, dac_o;
  logic       stb_o;

  always #10 clk = ~clk;

  dec_latch_top dut (
    .clk_i(clk), .rst_i(rst), .smp_i(smp), .ratio_sel_i(sel),
    .flip_i(flip), .dec_o(dec_o), .dec_stb_o(stb_o), .dac_o(dac_o)
  );

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  int   t = 0;
  int   mcode = 0;
  logic [7:0] exp_d = '0;
  bit   exp_s = 1'b0;
  bit   in_rst = 1'b0;
  int   stb_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0d)", tag, act, exp, t);
    end
  endtask

  // drive one cycle, advance the model across the next edge, check after it
  task automatic step(input logic [7:0] d, input logic [2:0] s, input bit f, input bit r);
    bit kept;
    smp = d; sel = s; flip = f; rst = r;
    in_rst = r;
    if (r) begin
      t = 0; mcode = int'(s); exp_d = '0; exp_s = 1'b0;
    end else begin
      kept = (t % (1 << mcode)) == 0;
      if (kept) exp_d = d;
      exp_s = kept;
      if (t % 128 == 127) mcode = int'(s);
      t++;
    end
    @(negedge clk);
    chk(stb_o == exp_s, in_rst ? "R8 strobe" : "R4 strobe", int'(stb_o), int'(exp_s));
    chk(dec_o == exp_d, in_rst ? "R8 data" : (exp_s ? "R2 data" : "R3 data"),
        int'(dec_o), int'(exp_d));
    chk(dac_o == (f ? exp_d : ~exp_d), f ? "R6 dac" : "R5 dac",
        int'(dac_o), int'(f ? exp_d : ~exp_d));
    if (stb_o) stb_cnt++;
  endtask

  // one 128-cycle frame; select switches to s_new from index change_at on
  task automatic run_frame(input logic [2:0] s_start, input logic [2:0] s_new,
                           input int change_at, input bit f, input int seed,
                           input string tag);
    int exp_cnt;
    exp_cnt = 128 >> mcode;
    stb_cnt = 0;
    for (int j = 0; j < 128; j++) begin
      logic [7:0] d;
      d = 8'((j * 37 + seed) ^ (seed << 3));
      step(d, (change_at >= 0 && j >= change_at) ? s_new : s_start, f, 1'b0);
    end
    chk(stb_cnt == exp_cnt, tag, stb_cnt, exp_cnt);
  endtask

  initial begin
    // R8: reset state
    step(8'hA5, 3'd0, 1'b0, 1'b1);
    step(8'h5A, 3'd0, 1'b1, 1'b1);

    // R1: every code, full frame right after reset
    for (int c = 0; c < 8; c++) begin
      step(8'h00, 3'(c), c[0], 1'b1);
      run_frame(3'(c), 3'(c), -1, c[0], c * 29 + 1, "R1 frame keeps");
    end

    // R7: mid-frame change keeps old ratio until wrap
    step(8'h00, 3'd1, 1'b0, 1'b1);
    run_frame(3'd1, 3'd3, 40, 1'b0, 91, "R7 old ratio kept");
    run_frame(3'd3, 3'd3, -1, 1'b1, 17, "R7 new ratio after wrap");
    // R7: change on the last cycle of a frame is adopted at that wrap
    run_frame(3'd3, 3'd0, 127, 1'b0, 200, "R7 old ratio kept");
    run_frame(3'd0, 3'd0, -1, 1'b0, 63, "R7 last-cycle change");

    // R8: reset in mid run, then first edge keeps a sample
    run_frame(3'd0, 3'd5, 10, 1'b1, 7, "R1 frame keeps");
    for (int j = 0; j < 37; j++) step(8'(j * 5), 3'd5, 1'b0, 1'b0);
    step(8'hFF, 3'd7, 1'b0, 1'b1);
    step(8'hC3, 3'd7, 1'b0, 1'b0);
    chk(stb_o == 1'b1 && dec_o == 8'hC3, "R8 first keep after release",
        int'(dec_o), 8'hC3);
    run_frame(3'd7, 3'd7, -1, 1'b1, 255, "R1 frame keeps");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule